// File: doc/BRIEF.md
# Host Pipe Status and Dual-Bank FIFO Controller

This block keeps the status flags of one host-side pipe and the two data banks behind them. A protocol engine, which lies outside this block, reports events: bytes landing in a bank, an IN packet completed, an OUT bank transmitted, a NAK, a STALL, an isochronous CRC error, and a level vector of pipe-error sources. Firmware sees an 8-bit status register. It acknowledges flags by writing zeros to it, and it moves payload through a byte-wide FIFO port. Bank ownership alternates between firmware and hardware. Firmware hands a bank back by clearing the FIFO-control flag, and the other bank then becomes current.

A separate enable register masks which flags drive the pipe interrupt. A STALL freezes the pipe. While the pipe is frozen, engine events are ignored until firmware pulses the unfreeze input. The bank depth is a parameter.

Status bit positions, MSB first: 7 FIFO control, 6 NAK seen, 5 read/write allowed, 4 pipe error, 3 setup-bank ready, 2 out-bank ready, 1 stall seen (CRC error on isochronous pipes), 0 IN data received. The pipe kind input uses these codes: 2'b00 SETUP, 2'b01 OUT, 2'b10 IN.

Top module: `hpipe_status`

## Requirements
- R1: While rst_n is low at a clock edge, status reads 8'h00, frozen is 0 and pipe_irq is 0.
- R2: On an OUT or SETUP pipe whose current bank is free, bit 7 rises in the same cycle as bit 2 (OUT) or bit 3 (SETUP). This happens on the first edge after reset is released and on the first edge after the current bank becomes free.
- R3: On OUT/SETUP pipes, a fifo_wr is accepted only while bit 5 is high. Bit 5 drops after DEPTH bytes have been written to the current bank.
- R4: On OUT/SETUP pipes, writing 0 to bit 7 while it is set commits the current bank and switches to the other bank, and bit 7 reads 0 after that edge. Once both banks are committed, bit 7 stays low until ev_tx_done frees a bank.
- R5: On IN pipes, eng_wr bytes followed by ev_in_done fill a bank. When that bank is current, bits 7 and 0 rise together. fifo_rdata then presents the bytes in arrival order, and bit 5 stays high until the last byte has been popped.
- R6: On IN pipes, writing 0 to bit 7 releases the current bank and advances to the other bank. If that bank is filled, its data appears with bits 7 and 0 one edge later.
- R7: A software write leaves bits 7, 6, 3, 2, 1 and 0 set where it writes 1 and clears them where it writes 0. Bits 5 and 4 ignore software writes.
- R8: Bit 5 is 0 whenever the stall flag (bit 1 on a non-isochronous pipe) or bit 4 is set.
- R9: On a non-isochronous pipe, ev_stall sets bit 1 and raises frozen. While frozen, ev_nak, ev_stall, ev_crc, eng_wr, ev_in_done and ev_tx_done are ignored. A pulse on unfreeze clears frozen and leaves the flags as they are.
- R10: Bit 4 equals the OR of err_src one cycle earlier, so it clears itself once all source bits are 0.
- R11: With cfg_iso high, ev_crc sets bit 1 and ev_stall is ignored without freezing. Bit 1 then interrupts through enable bit 3, not enable bit 1.
- R12: pipe_irq is high exactly when a status bit 6, 4, 3, 2 or 1 is set together with the enable bit at the same position. Enable bits 7, 5 and 0 never raise pipe_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_kind | input | 2 | Pipe kind: 00 SETUP, 01 OUT, 10 IN |
| cfg_iso | input | 1 | Pipe is isochronous |
| eng_wr | input | 1 | Engine stores one IN byte |
| eng_wdata | input | 8 | IN byte from engine |
| ev_in_done | input | 1 | Engine finished an IN packet |
| ev_tx_done | input | 1 | Engine finished sending an OUT/SETUP bank |
| ev_nak | input | 1 | NAK handshake received |
| ev_stall | input | 1 | STALL handshake received |
| ev_crc | input | 1 | Isochronous CRC error |
| err_src | input | ERRW | Pipe-error source bits (level) |
| sw_wr | input | 1 | Firmware write strobe for the status register |
| sw_wdata | input | 8 | Firmware write data for the status register |
| status | output | 8 | Status register |
| ien_wr | input | 1 | Firmware write strobe for the enable register |
| ien_wdata | input | 8 | Enable register data |
| fifo_wr | input | 1 | Firmware pushes one byte (OUT/SETUP) |
| fifo_wdata | input | 8 | Firmware byte to push |
| fifo_rd | input | 1 | Firmware pops one byte (IN) |
| fifo_rdata | output | 8 | Byte at the read position of the current bank |
| unfreeze | input | 1 | Firmware releases a frozen pipe |
| frozen | output | 1 | Pipe is frozen |
| pipe_irq | output | 1 | Masked pipe interrupt |

## Verification
The bank hand-over is exercised with three patterns. The first fills the current OUT bank to its depth, which separates a full bank from one that merely owns data. The second commits both OUT banks back to back, so that only a transmit completion can revive bit 7. The third queues two IN packets ahead of the firmware, which shows whether releasing a bank exposes the second packet in its own order. Sweeping the enable register over a fixed flag state tells masked interrupt sources from unmasked ones. Separate runs with stall, pipe error and isochronous CRC show which flag forces the access bit low or freezes the pipe, and which enable bit the CRC flag follows.

// File: rtl/hpipe_pkg.sv
// Shared definitions for the host pipe status block.
// Assumes one pipe per instance; bit positions are those firmware decodes.
package hpipe_pkg;

    typedef enum logic [1:0] {
        PK_SETUP = 2'b00,
        PK_OUT   = 2'b01,
        PK_IN    = 2'b10
    } pipe_kind_e;

    localparam int B_FIFOCON = 7;
    localparam int B_NAK     = 6;
    localparam int B_RWAL    = 5;
    localparam int B_PERR    = 4;
    localparam int B_SETUP   = 3;
    localparam int B_OUT     = 2;
    localparam int B_STALL   = 1;
    localparam int B_INRX    = 0;

endpackage

// File: rtl/hpipe_bank_store.sv
// Two data banks with per-bank fill and read counters and ownership bits.
// Firmware works on the current bank, the engine on the hardware bank.
// Assumes callers qualify every strobe (room, ownership, pipe kind).
module hpipe_bank_store #(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          is_in,
    input  logic          fw_push,
    input  logic [7:0]    fw_wdata,
    input  logic          fw_pop,
    input  logic          cur_handoff,
    input  logic          hw_push,
    input  logic [7:0]    hw_wdata,
    input  logic          hw_handoff,
    output logic          cur_busy,
    output logic          hwb_busy,
    output logic [CW-1:0] cur_cnt,
    output logic [CW-1:0] cur_rdp,
    output logic [CW-1:0] hwb_cnt,
    output logic [7:0]    cur_rdata
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic          cur_q;
    logic          hwb_q;
    logic [1:0]    busy_w;
    logic [CW-1:0] cnt_w [2];
    logic [CW-1:0] rdp_w [2];
    logic [7:0]    rd_w  [2];

    // Bank pointers: each side toggles on its own hand-over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= 1'b0;
            hwb_q <= 1'b0;
        end else begin
            if (cur_handoff) cur_q <= ~cur_q;
            if (hw_handoff)  hwb_q <= ~hwb_q;
        end
    end

    for (genvar b = 0; b < 2; b++) begin : g_bank
        localparam logic BID = (b == 1);
        logic          fw_here;
        logic          hw_here;
        logic          wipe;
        logic          busy_q;
        logic [CW-1:0] cnt_q;
        logic [CW-1:0] rdp_q;
        logic [7:0]    mem_q [DEPTH];

        assign fw_here = (cur_q == BID);
        assign hw_here = (hwb_q == BID);
        // A bank is emptied when firmware frees an IN bank or the engine sends an OUT bank.
        assign wipe = (cur_handoff && fw_here && is_in) ||
                      (hw_handoff && hw_here && !is_in);

        // Ownership: set when a bank holds work for the other side.
        always_ff @(posedge clk) begin
            if (!rst_n)                      busy_q <= 1'b0;
            else if (cur_handoff && fw_here) busy_q <= !is_in;
            else if (hw_handoff && hw_here)  busy_q <= is_in;
        end

        // Fill counter of this bank.
        always_ff @(posedge clk) begin
            if (!rst_n)                                      cnt_q <= '0;
            else if (wipe)                                   cnt_q <= '0;
            else if ((fw_push && fw_here) || (hw_push && hw_here)) cnt_q <= cnt_q + 1'b1;
        end

        // Read counter of this bank.
        always_ff @(posedge clk) begin
            if (!rst_n)                  rdp_q <= '0;
            else if (wipe)               rdp_q <= '0;
            else if (fw_pop && fw_here)  rdp_q <= rdp_q + 1'b1;
        end

        // Byte storage written at the fill position.
        always_ff @(posedge clk) begin
            if (fw_push && fw_here)      mem_q[cnt_q[AW-1:0]] <= fw_wdata;
            else if (hw_push && hw_here) mem_q[cnt_q[AW-1:0]] <= hw_wdata;
        end

        assign busy_w[b] = busy_q;
        assign cnt_w[b]  = cnt_q;
        assign rdp_w[b]  = rdp_q;
        assign rd_w[b]   = (rdp_q < DEPTH_C) ? mem_q[rdp_q[AW-1:0]] : 8'h00;
    end

    assign cur_busy  = busy_w[cur_q];
    assign hwb_busy  = busy_w[hwb_q];
    assign cur_cnt   = cnt_w[cur_q];
    assign cur_rdp   = rdp_w[cur_q];
    assign hwb_cnt   = cnt_w[hwb_q];
    assign cur_rdata = rd_w[cur_q];

endmodule

// File: rtl/hpipe_flags.sv
// Status flag register of one pipe plus the freeze state.
// Hardware sets flags, software only clears them by writing zeros.
// Assumes event inputs are already qualified by pipe kind and freeze.
module hpipe_flags
    import hpipe_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pipe_kind_e    kind,
    input  logic          iso,
    input  logic          sw_wr,
    input  logic [7:0]    sw_wdata,
    input  logic          nak_ev,
    input  logic          stall_ev,
    input  logic          crc_ev,
    input  logic          err_any,
    input  logic          unfreeze,
    input  logic          cur_busy,
    input  logic [CW-1:0] cur_cnt,
    input  logic [CW-1:0] cur_rdp,
    output logic [7:0]    status,
    output logic          frozen,
    output logic          cur_handoff
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic       fc_q, nak_q, perr_q, stp_q, out_q, stc_q, inr_q, frz_q;
    logic       is_in;
    logic       set_fc;
    logic       rwal;
    logic [7:0] clr;
    logic       unused_wbits;

    assign is_in        = (kind == PK_IN);
    assign clr          = sw_wr ? ~sw_wdata : 8'h00;
    assign unused_wbits = ^{sw_wdata[B_RWAL], sw_wdata[B_PERR]};
    // Firmware takes a bank: OUT side when it is free, IN side when it holds data.
    assign set_fc       = !fc_q && (is_in ? cur_busy : !cur_busy);
    assign cur_handoff  = sw_wr && fc_q && !sw_wdata[B_FIFOCON];

    // Access allowed: bank owned, room or data left, no stall or error.
    always_comb begin
        rwal = fc_q && !(stc_q && !iso) && !perr_q;
        if (is_in) rwal = rwal && (cur_rdp < cur_cnt);
        else       rwal = rwal && (cur_cnt < DEPTH_C);
    end

    // FIFO-control flag: hardware grant, software hand-over.
    always_ff @(posedge clk) begin
        if (!rst_n)           fc_q <= 1'b0;
        else if (cur_handoff) fc_q <= 1'b0;
        else if (set_fc)      fc_q <= 1'b1;
    end

    // Event flags: a hardware set wins over a software clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nak_q <= 1'b0;
            stp_q <= 1'b0;
            out_q <= 1'b0;
            inr_q <= 1'b0;
            stc_q <= 1'b0;
        end else begin
            nak_q <= nak_ev | (nak_q & ~clr[B_NAK]);
            stp_q <= (set_fc && kind == PK_SETUP) | (stp_q & ~clr[B_SETUP]);
            out_q <= (set_fc && kind == PK_OUT) | (out_q & ~clr[B_OUT]);
            inr_q <= (set_fc && is_in) | (inr_q & ~clr[B_INRX]);
            stc_q <= stall_ev | crc_ev | (stc_q & ~clr[B_STALL]);
        end
    end

    // Pipe-error flag mirrors the error sources one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) perr_q <= 1'b0;
        else        perr_q <= err_any;
    end

    // Freeze: raised by a stall, dropped by the firmware release.
    always_ff @(posedge clk) begin
        if (!rst_n) frz_q <= 1'b0;
        else        frz_q <= stall_ev | (frz_q & ~unfreeze);
    end

    assign status = {fc_q, nak_q, rwal, perr_q, stp_q, out_q, stc_q, inr_q};
    assign frozen = frz_q;

endmodule

// File: rtl/hpipe_irq.sv
// Interrupt enable register and masking of the status flags.
// On isochronous pipes the CRC flag in bit 1 uses the setup-ready enable.
module hpipe_irq
    import hpipe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       iso,
    input  logic       ien_wr,
    input  logic [7:0] ien_wdata,
    input  logic [7:0] status,
    output logic       irq
);

    logic en_nak, en_perr, en_stp, en_out, en_stall;
    logic bit1_en;
    logic unused_bits;

    assign unused_bits = ^{ien_wdata[B_FIFOCON], ien_wdata[B_RWAL], ien_wdata[B_INRX],
                           status[B_FIFOCON], status[B_RWAL], status[B_INRX]};

    // Enable register: only interrupt-capable positions are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_nak   <= 1'b0;
            en_perr  <= 1'b0;
            en_stp   <= 1'b0;
            en_out   <= 1'b0;
            en_stall <= 1'b0;
        end else if (ien_wr) begin
            en_nak   <= ien_wdata[B_NAK];
            en_perr  <= ien_wdata[B_PERR];
            en_stp   <= ien_wdata[B_SETUP];
            en_out   <= ien_wdata[B_OUT];
            en_stall <= ien_wdata[B_STALL];
        end
    end

    assign bit1_en = iso ? en_stp : en_stall;

    // Combine masked sources into one interrupt line.
    always_comb begin
        irq = (status[B_NAK]   && en_nak)  ||
              (status[B_PERR]  && en_perr) ||
              (status[B_SETUP] && en_stp)  ||
              (status[B_OUT]   && en_out)  ||
              (status[B_STALL] && bit1_en);
    end

endmodule

// File: rtl/hpipe_status.sv
// Top of the host pipe status block: qualifies engine and firmware strobes,
// then ties the bank store, the flag register and the interrupt mask together.
// Assumes cfg_kind and cfg_iso change only while rst_n is low.
module hpipe_status
    import hpipe_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int ERRW  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      cfg_kind,
    input  logic            cfg_iso,
    input  logic            eng_wr,
    input  logic [7:0]      eng_wdata,
    input  logic            ev_in_done,
    input  logic            ev_tx_done,
    input  logic            ev_nak,
    input  logic            ev_stall,
    input  logic            ev_crc,
    input  logic [ERRW-1:0] err_src,
    input  logic            sw_wr,
    input  logic [7:0]      sw_wdata,
    output logic [7:0]      status,
    input  logic            ien_wr,
    input  logic [7:0]      ien_wdata,
    input  logic            fifo_wr,
    input  logic [7:0]      fifo_wdata,
    input  logic            fifo_rd,
    output logic [7:0]      fifo_rdata,
    input  logic            unfreeze,
    output logic            frozen,
    output logic            pipe_irq
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    pipe_kind_e    kind;
    logic          is_in;
    logic          live;
    logic          fw_push, fw_pop, hw_push, hw_handoff, cur_handoff;
    logic          nak_ev, stall_ev, crc_ev;
    logic          cur_busy, hwb_busy;
    logic [CW-1:0] cur_cnt, cur_rdp, hwb_cnt;
    logic [7:0]    stat_w;

    assign kind  = pipe_kind_e'(cfg_kind);
    assign is_in = (kind == PK_IN);
    assign live  = !frozen;

    // Strobe qualification against direction, ownership, room and freeze.
    always_comb begin
        fw_push    = fifo_wr && !is_in && stat_w[B_RWAL];
        fw_pop     = fifo_rd && is_in && stat_w[B_RWAL];
        hw_push    = eng_wr && is_in && live && !hwb_busy && (hwb_cnt < DEPTH_C);
        hw_handoff = live && ((ev_in_done && is_in && !hwb_busy) ||
                              (ev_tx_done && !is_in && hwb_busy));
        nak_ev     = ev_nak && live;
        stall_ev   = ev_stall && !cfg_iso && live;
        crc_ev     = ev_crc && cfg_iso && live;
    end

    hpipe_bank_store #(.DEPTH(DEPTH), .CW(CW)) u_banks (
        .clk         (clk),
        .rst_n       (rst_n),
        .is_in       (is_in),
        .fw_push     (fw_push),
        .fw_wdata    (fifo_wdata),
        .fw_pop      (fw_pop),
        .cur_handoff (cur_handoff),
        .hw_push     (hw_push),
        .hw_wdata    (eng_wdata),
        .hw_handoff  (hw_handoff),
        .cur_busy    (cur_busy),
        .hwb_busy    (hwb_busy),
        .cur_cnt     (cur_cnt),
        .cur_rdp     (cur_rdp),
        .hwb_cnt     (hwb_cnt),
        .cur_rdata   (fifo_rdata)
    );

    hpipe_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .kind        (kind),
        .iso         (cfg_iso),
        .sw_wr       (sw_wr),
        .sw_wdata    (sw_wdata),
        .nak_ev      (nak_ev),
        .stall_ev    (stall_ev),
        .crc_ev      (crc_ev),
        .err_any     (|err_src),
        .unfreeze    (unfreeze),
        .cur_busy    (cur_busy),
        .cur_cnt     (cur_cnt),
        .cur_rdp     (cur_rdp),
        .status      (stat_w),
        .frozen      (frozen),
        .cur_handoff (cur_handoff)
    );

    hpipe_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .iso       (cfg_iso),
        .ien_wr    (ien_wr),
        .ien_wdata (ien_wdata),
        .status    (stat_w),
        .irq       (pipe_irq)
    );

    assign status = stat_w;

endmodule

// File: rtl/hpipe_status_chk.sv
// Property checker for hpipe_status, attached through bind below.
module hpipe_status_chk #(
    parameter int ERRW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_iso,
    input logic            ev_nak,
    input logic            ev_stall,
    input logic [ERRW-1:0] err_src,
    input logic            sw_wr,
    input logic [7:0]      sw_wdata,
    input logic [7:0]      status,
    input logic            unfreeze,
    input logic            frozen,
    input logic            pipe_irq
);

    // R7
    sw_one_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && sw_wdata[6] && !status[6] && !ev_nak) |=> !status[6]);

    // R4
    handover_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && status[7] && !sw_wdata[7]) |=> !status[7]);

    // R8
    access_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status[1] && !cfg_iso) || status[4]) |-> !status[5]);

    // R9
    stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stall && !cfg_iso && !frozen) |=> frozen);

    // R9
    frozen_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && ev_nak && !status[6]) |=> !status[6]);

    // R9
    unfreeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unfreeze && !(ev_stall && !cfg_iso)) |=> !frozen);

    // R10
    perr_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status[4] == (|$past(err_src))));

    // R12
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[6] || status[4] || status[3] || status[2] || status[1]) |-> !pipe_irq);

endmodule

bind hpipe_status hpipe_status_chk #(.ERRW(ERRW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_iso  (cfg_iso),
    .ev_nak   (ev_nak),
    .ev_stall (ev_stall),
    .err_src  (err_src),
    .sw_wr    (sw_wr),
    .sw_wdata (sw_wdata),
    .status   (status),
    .unfreeze (unfreeze),
    .frozen   (frozen),
    .pipe_irq (pipe_irq)
);

// File: tb/hpipe_status_test.sv
module hpipe_status_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int ERRW       = 4;

    // Enable value and expected interrupt with NAK and out-ready set.
    localparam logic [8:0] IRQ_TAB [10] = '{
        {8'h00, 1'b0}, {8'h40, 1'b1}, {8'h04, 1'b1}, {8'h80, 1'b0},
        {8'h20, 1'b0}, {8'h01, 1'b0}, {8'h10, 1'b0}, {8'h08, 1'b0},
        {8'h02, 1'b0}, {8'hFF, 1'b1}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      cfg_kind = 2'b01;
    logic            cfg_iso = 1'b0;
    logic            eng_wr = 1'b0;
    logic [7:0]      eng_wdata = 8'h00;
    logic            ev_in_done = 1'b0;
    logic            ev_tx_done = 1'b0;
    logic            ev_nak = 1'b0;
    logic            ev_stall = 1'b0;
    logic            ev_crc = 1'b0;
    logic [ERRW-1:0] err_src = '0;
    logic            sw_wr = 1'b0;
    logic [7:0]      sw_wdata = 8'h00;
    logic [7:0]      status;
    logic            ien_wr = 1'b0;
    logic [7:0]      ien_wdata = 8'h00;
    logic            fifo_wr = 1'b0;
    logic [7:0]      fifo_wdata = 8'h00;
    logic            fifo_rd = 1'b0;
    logic [7:0]      fifo_rdata;
    logic            unfreeze = 1'b0;
    logic            frozen;
    logic            pipe_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hpipe_status #(.DEPTH(DEPTH), .ERRW(ERRW)) uut (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sw_write(input logic [7:0] v);
        sw_wr = 1'b1; sw_wdata = v; tick(); sw_wr = 1'b0;
    endtask

    task automatic ien_write(input logic [7:0] v);
        ien_wr = 1'b1; ien_wdata = v; tick(); ien_wr = 1'b0;
    endtask

    task automatic do_reset(input logic [1:0] k, input logic iso);
        rst_n = 1'b0; cfg_kind = k; cfg_iso = iso; err_src = '0;
        tick(); tick();
        chk("R1 status", status, 8'h00);
        chk("R1 frozen", frozen, 1'b0);
        chk("R1 irq", pipe_irq, 1'b0);
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        // OUT pipe: grant after reset, then enable sweep
        do_reset(2'b01, 1'b0);
        chk("R2 out grant", status, 8'hA4);
        ev_nak = 1'b1; tick(); ev_nak = 1'b0;
        chk("R12 nak set", status, 8'hE4);
        for (int i = 0; i < 10; i++) begin
            ien_write(IRQ_TAB[i][8:1]);
            chk("R12 irq mask", pipe_irq, IRQ_TAB[i][0]);
        end
        ien_write(8'h00);
        sw_write(8'hBF);
        chk("R7 nak clear", status, 8'hA4);

        // R3: fill current bank
        for (int i = 0; i < DEPTH; i++) begin
            fifo_wr = 1'b1; fifo_wdata = 8'(i); tick();
            if (i == DEPTH - 2) chk("R3 room left", status[5], 1'b1);
        end
        fifo_wr = 1'b0;
        chk("R3 bank full", status, 8'h84);

        // R4: commit both banks
        sw_write(8'h00);
        chk("R4 commit clears", status, 8'h00);
        tick();
        chk("R4 second bank", status, 8'hA4);
        sw_write(8'h7F);
        chk("R4 only bit7 cleared", status, 8'h04);
        tick();
        chk("R4 both busy", status, 8'h04);
        ev_tx_done = 1'b1; tick(); ev_tx_done = 1'b0;
        chk("R4 freed pending", status, 8'h04);
        tick();
        chk("R4 regrant", status, 8'hA4);

        // R7: writes of one and read-only bits
        sw_write(8'hFF);
        chk("R7 ones ignored", status, 8'hA4);
        sw_write(8'hFB);
        chk("R7 out clear", status, 8'hA0);
        sw_write(8'hDF);
        chk("R7 bit5 read-only", status, 8'hA0);

        // SETUP pipe grant
        do_reset(2'b00, 1'b0);
        chk("R2 setup grant", status, 8'hA8);

        // R8/R9: stall and freeze
        do_reset(2'b01, 1'b0);
        ev_stall = 1'b1; tick(); ev_stall = 1'b0;
        chk("R8 stall blocks", status, 8'h86);
        chk("R9 frozen", frozen, 1'b1);
        ev_nak = 1'b1; tick(); ev_nak = 1'b0;
        chk("R9 nak ignored", status, 8'h86);
        unfreeze = 1'b1; tick(); unfreeze = 1'b0;
        chk("R9 unfrozen", frozen, 1'b0);
        chk("R9 flags kept", status, 8'h86);
        ev_nak = 1'b1; tick(); ev_nak = 1'b0;
        chk("R9 nak after unfreeze", status, 8'hC6);
        sw_write(8'hFD);
        chk("R8 access back", status, 8'hE4);

        // R10: pipe error follows sources
        do_reset(2'b01, 1'b0);
        err_src = 4'b0100; tick();
        chk("R10 perr set", status, 8'h94);
        sw_write(8'hFF);
        chk("R10 perr write ignored", status, 8'h94);
        ien_write(8'h10);
        chk("R12 perr irq", pipe_irq, 1'b1);
        err_src = '0; tick();
        chk("R10 perr self clear", status, 8'hA4);

        // R5/R6: IN pipe with two queued packets
        do_reset(2'b10, 1'b0);
        chk("R5 idle", status, 8'h00);
        eng_wr = 1'b1;
        eng_wdata = 8'h11; tick();
        eng_wdata = 8'h22; tick();
        eng_wdata = 8'h33; tick();
        eng_wr = 1'b0;
        ev_in_done = 1'b1; tick(); ev_in_done = 1'b0;
        chk("R5 not yet granted", status, 8'h00);
        eng_wr = 1'b1; eng_wdata = 8'h44; tick(); eng_wr = 1'b0;
        chk("R5 grant", status, 8'hA1);
        chk("R5 byte0", fifo_rdata, 8'h11);
        ev_in_done = 1'b1; tick(); ev_in_done = 1'b0;
        fifo_rd = 1'b1; tick();
        chk("R5 byte1", fifo_rdata, 8'h22);
        tick();
        chk("R5 byte2", fifo_rdata, 8'h33);
        tick();
        fifo_rd = 1'b0;
        chk("R5 empty", status, 8'h81);
        sw_write(8'hFE);
        chk("R7 in clear", status, 8'h80);
        sw_write(8'h7F);
        chk("R6 release", status, 8'h00);
        tick();
        chk("R6 next packet", status, 8'hA1);
        chk("R6 next data", fifo_rdata, 8'h44);

        // R11: isochronous CRC
        do_reset(2'b10, 1'b1);
        ev_stall = 1'b1; tick(); ev_stall = 1'b0;
        chk("R11 stall ignored", status, 8'h00);
        chk("R11 no freeze", frozen, 1'b0);
        ev_crc = 1'b1; tick(); ev_crc = 1'b0;
        chk("R11 crc flag", status, 8'h02);
        ien_write(8'h02);
        chk("R11 stall enable no irq", pipe_irq, 1'b0);
        ien_write(8'h08);
        chk("R11 setup enable irq", pipe_irq, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule